// File: doc/BRIEF.md
# Four-Channel Triggered DMA Controller

The block copies blocks of 16-bit or 32-bit units from one address to another over a simple synchronous memory bus, on behalf of four independent channels. Software programs each channel through a small write port. It sets a source address, a destination address, a unit count and a control word. Setting the enable bit arms the channel. A channel then starts at once, or it waits for a horizontal-blank pulse, a vertical-blank pulse or a per-channel external request. Each channel steps its source and its destination on its own. A channel can repeat on every later trigger and can raise a one-cycle interrupt when a block completes.

A single transfer engine serves every channel. It is a four-state machine. ST_IDLE picks the lowest-numbered pending channel and moves to ST_READ. ST_READ holds a read request until the bus is ready, then moves to ST_WRITE. ST_WRITE holds a write request until the bus is ready. From there it returns to ST_READ while units remain, or goes to ST_DONE after the last unit. ST_DONE hands the final addresses back to the channel and returns to ST_IDLE. The channel then either disarms itself or reloads for its next trigger.

Top module: `dma4_ctrl`

## Requirements
- R1: A write to the source register (reg_sel 0) or to the destination register (reg_sel 1) stores the address with bit 0 forced to zero. A source written as 0x1001 is read from 0x1000.
- R2: Control bit 5 selects 32-bit units. In that mode the bus addresses are aligned down to a multiple of 4 and bus_wide is high. In 16-bit mode bus_wdata carries the low half of the data read, with the upper 16 bits zero.
- R3: A count register (reg_sel 2, bits 15:0) of zero means ZERO_CNT units on channels 0 to 2, and ZERO_CNT_LAST units on channel 3.
- R4: Source mode (control bits 3:2) and destination mode (control bits 1:0) step each address on its own. Code 0 increments, 1 decrements, 2 holds fixed and 3 increments. The step is 2 bytes in 16-bit mode and 4 bytes in 32-bit mode.
- R5: The channel loads its working source, destination and count only when the enable bit (control bit 15, reg_sel 3) goes from 0 to 1. Later writes to the address or count registers do not affect a transfer that is already armed.
- R6: Control bits 7:6 select the start timing. Code 0 starts at once, 1 on hblank, 2 on vblank and 3 on the channel's special_req bit. An armed channel moves no data until its trigger occurs.
- R7: A special request on channel 0 is ignored. The channel moves no data and stays enabled.
- R8: When a non-repeating block completes, the channel clears bit 15 of its control word as read on ctrl_rdata. The control word reads as zero after reset.
- R9: When a repeating block (control bit 4) completes, the channel reloads its count and stays enabled. It reloads its destination only in mode 3. Its source carries on from where it stopped. It then waits for its next trigger.
- R10: With control bit 8 set, a channel pulses its own irq bit for exactly one cycle when a block completes. With bit 8 clear, it raises no interrupt.
- R11: When several channels are pending, the lowest-numbered one runs its whole block before any other channel starts.
- R12: Each unit is a read followed by a write. Each access holds bus_req, bus_we and bus_addr steady until bus_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_chan | input | 2 | Channel addressed by a write |
| reg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| reg_wdata | input | 32 | Register write data |
| rd_chan | input | 2 | Channel whose control word appears on ctrl_rdata |
| ctrl_rdata | output | 16 | Control word readback |
| hblank | input | 1 | Horizontal-blank trigger pulse |
| vblank | input | 1 | Vertical-blank trigger pulse |
| special_req | input | 4 | Per-channel special trigger |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 for a write, 0 for a read |
| bus_wide | output | 1 | 1 for a 32-bit unit |
| bus_addr | output | 32 | Access address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid while bus_ready is high on a read |
| bus_ready | input | 1 | Access completes on this cycle |
| irq | output | 4 | Per-channel completion pulse |

## Verification
The bench builds the controller with ZERO_CNT set to 3 and ZERO_CNT_LAST set to 5. With those values, both meanings of a zero count run to completion in a few dozen cycles, and each expected write can be listed one by one. The default values would need tens of thousands of units. The bench also stalls bus_ready one cycle in four, so every access must hold its request across a wait.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

    parameter int ADDR_W      = 32;
    parameter int CNT_FIELD_W = 16;

    typedef enum logic [1:0] {AM_INC = 2'd0, AM_DEC = 2'd1, AM_FIX = 2'd2, AM_INC_RLD = 2'd3} addr_mode_e;
    typedef enum logic [1:0] {TM_NOW = 2'd0, TM_HBL = 2'd1, TM_VBL = 2'd2, TM_SPC = 2'd3} timing_e;
    typedef enum logic [1:0] {RS_SRC = 2'd0, RS_DST = 2'd1, RS_CNT = 2'd2, RS_CTRL = 2'd3} reg_sel_e;
    typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_DONE} eng_state_e;

    typedef struct packed {
        logic       en;
        logic [5:0] rsv;
        logic       irq_en;
        timing_e    timing;
        logic       wide;
        logic       rpt;
        addr_mode_e smode;
        addr_mode_e dmode;
    } ctrl_t;

    function automatic logic [ADDR_W-1:0] step_addr(logic [ADDR_W-1:0] a, addr_mode_e m, logic wide);
        logic [ADDR_W-1:0] d;
        d = wide ? ADDR_W'(4) : ADDR_W'(2);
        case (m)
            AM_DEC:  return a - d;
            AM_FIX:  return a;
            default: return a + d;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] align_addr(logic [ADDR_W-1:0] a, logic wide);
        return wide ? {a[ADDR_W-1:2], 2'b00} : a;
    endfunction

endpackage

// File: rtl/dma4_chan.sv
module dma4_chan
    import dma4_pkg::*;
#(
    parameter int CH_ID      = 0,
    parameter int CNT_W      = 17,
    parameter int ZERO_UNITS = 16384
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          wr_sel,
    input  logic [31:0]       wr_data,
    input  logic              hblank,
    input  logic              vblank,
    input  logic              special,
    input  logic              grant,
    input  logic              wb_valid,
    input  logic [ADDR_W-1:0] wb_src,
    input  logic [ADDR_W-1:0] wb_dst,
    output ctrl_t             ctrl,
    output logic [ADDR_W-1:0] work_src,
    output logic [ADDR_W-1:0] work_dst,
    output logic [CNT_W-1:0]  work_cnt,
    output logic              pending,
    output logic              irq
);

    logic [ADDR_W-1:0]      src_q, dst_q;
    logic [CNT_FIELD_W-1:0] cnt_q;
    logic [CNT_W-1:0]       reload;
    ctrl_t                  new_ctrl;
    logic                   trig, ctrl_wr;

    always_comb begin
        new_ctrl     = ctrl_t'(wr_data[15:0]);
        new_ctrl.rsv = '0;
    end

    assign reload  = (cnt_q == '0) ? CNT_W'(ZERO_UNITS) : CNT_W'(cnt_q);
    assign ctrl_wr = wr_en && (wr_sel == RS_CTRL);
    assign trig    = ctrl.en && ((ctrl.timing == TM_HBL && hblank) ||
                                 (ctrl.timing == TM_VBL && vblank) ||
                                 (ctrl.timing == TM_SPC && special && (CH_ID != 0)));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q    <= '0;
            dst_q    <= '0;
            cnt_q    <= '0;
            ctrl     <= '0;
            work_src <= '0;
            work_dst <= '0;
            work_cnt <= '0;
            pending  <= 1'b0;
            irq      <= 1'b0;
        end else begin
            irq     <= wb_valid && ctrl.irq_en;
            pending <= (pending && !grant) || trig;
            if (wr_en) begin
                unique case (wr_sel)
                    RS_SRC: src_q <= {wr_data[ADDR_W-1:1], 1'b0};
                    RS_DST: dst_q <= {wr_data[ADDR_W-1:1], 1'b0};
                    RS_CNT: cnt_q <= wr_data[CNT_FIELD_W-1:0];
                    RS_CTRL: begin
                        ctrl <= new_ctrl;
                        if (new_ctrl.en && !ctrl.en) begin
                            work_src <= src_q;
                            work_dst <= dst_q;
                            work_cnt <= reload;
                            pending  <= (new_ctrl.timing == TM_NOW);
                        end else if (!new_ctrl.en) begin
                            pending <= 1'b0;
                        end
                    end
                endcase
            end
            if (wb_valid) begin
                work_src <= wb_src;
                if (ctrl.rpt) begin
                    work_cnt <= reload;
                    work_dst <= (ctrl.dmode == AM_INC_RLD) ? dst_q : wb_dst;
                    if (ctrl.timing == TM_NOW) pending <= 1'b1;
                end else begin
                    work_dst <= wb_dst;
                    work_cnt <= '0;
                    ctrl.en  <= 1'b0;
                end
            end
        end
    end

    // R8: a finished single-shot block leaves the enable bit clear
    p_en_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !ctrl.rpt && !ctrl_wr) |=> !ctrl.en);

    // R10: completion interrupt lasts one cycle
    p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R7: a special request never arms channel 0
    p_no_special0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (CH_ID == 0 && ctrl.en && ctrl.timing == TM_SPC && !pending && !ctrl_wr) |=> !pending);

    // R9: a repeating block stays enabled after completion
    p_rpt_keeps_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && ctrl.rpt && ctrl.en && !ctrl_wr) |=> ctrl.en);

endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
    import dma4_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 17,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pend,
    input  ctrl_t             ch_ctrl [NUM_CH],
    input  logic [ADDR_W-1:0] ch_src  [NUM_CH],
    input  logic [ADDR_W-1:0] ch_dst  [NUM_CH],
    input  logic [CNT_W-1:0]  ch_cnt  [NUM_CH],
    output logic              bus_req,
    output logic              bus_we,
    output logic              bus_wide,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_ready,
    output logic [NUM_CH-1:0] grant,
    output logic              wb_valid,
    output logic [CH_W-1:0]   wb_chan,
    output logic [ADDR_W-1:0] wb_src,
    output logic [ADDR_W-1:0] wb_dst
);

    eng_state_e        state, nxt;
    logic [CH_W-1:0]   sel, act;
    logic              any;
    logic [ADDR_W-1:0] a_src, a_dst;
    logic [CNT_W-1:0]  a_cnt;
    addr_mode_e        a_sm, a_dm;
    logic              a_wide;
    logic [31:0]       data_q;

    // lowest-numbered pending channel wins
    always_comb begin
        sel = '0;
        any = 1'b0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (pend[i]) begin
                sel = CH_W'(i);
                any = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (any) nxt = ST_READ;
            ST_READ:  if (bus_ready) nxt = ST_WRITE;
            ST_WRITE: if (bus_ready) nxt = (a_cnt == CNT_W'(1)) ? ST_DONE : ST_READ;
            ST_DONE:  nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        bus_req  = (state == ST_READ) || (state == ST_WRITE);
        bus_we   = (state == ST_WRITE);
        grant    = '0;
        wb_valid = (state == ST_DONE);
        if (state == ST_IDLE && any) grant[sel] = 1'b1;
    end

    assign bus_wide  = a_wide;
    assign bus_addr  = align_addr((state == ST_WRITE) ? a_dst : a_src, a_wide);
    assign bus_wdata = a_wide ? data_q : {16'h0000, data_q[15:0]};
    assign wb_chan   = act;
    assign wb_src    = a_src;
    assign wb_dst    = a_dst;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act    <= '0;
            a_src  <= '0;
            a_dst  <= '0;
            a_cnt  <= '0;
            a_sm   <= AM_INC;
            a_dm   <= AM_INC;
            a_wide <= 1'b0;
            data_q <= '0;
        end else begin
            if (state == ST_IDLE && any) begin
                act    <= sel;
                a_src  <= ch_src[sel];
                a_dst  <= ch_dst[sel];
                a_cnt  <= ch_cnt[sel];
                a_sm   <= ch_ctrl[sel].smode;
                a_dm   <= ch_ctrl[sel].dmode;
                a_wide <= ch_ctrl[sel].wide;
            end
            if (state == ST_READ && bus_ready) data_q <= bus_rdata;
            if (state == ST_WRITE && bus_ready) begin
                a_src <= step_addr(a_src, a_sm, a_wide);
                a_dst <= step_addr(a_dst, a_dm, a_wide);
                a_cnt <= a_cnt - CNT_W'(1);
            end
        end
    end

    // R12: an access waits with steady request and address
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

    // R12: a completed read is followed by its write
    p_read_then_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_ready) |=> (bus_req && bus_we));

    // R11: at most one channel granted at a time
    p_one_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R11: no new grant while a block is in flight
    p_no_grant_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (grant == '0));

endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
    import dma4_pkg::*;
#(
    parameter int NUM_CH        = 4,
    parameter int ZERO_CNT      = 32'h4000,
    parameter int ZERO_CNT_LAST = 32'h10000,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int CNT_W = $clog2(ZERO_CNT_LAST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [CH_W-1:0]   reg_chan,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    input  logic [CH_W-1:0]   rd_chan,
    output logic [15:0]       ctrl_rdata,
    input  logic              hblank,
    input  logic              vblank,
    input  logic [NUM_CH-1:0] special_req,
    output logic              bus_req,
    output logic              bus_we,
    output logic              bus_wide,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_ready,
    output logic [NUM_CH-1:0] irq
);

    ctrl_t             ctrl_a [NUM_CH];
    logic [ADDR_W-1:0] src_a  [NUM_CH];
    logic [ADDR_W-1:0] dst_a  [NUM_CH];
    logic [CNT_W-1:0]  cnt_a  [NUM_CH];
    logic [NUM_CH-1:0] pend, grant;
    logic              wb_valid;
    logic [CH_W-1:0]   wb_chan;
    logic [ADDR_W-1:0] wb_src, wb_dst;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dma4_chan #(
            .CH_ID      (g),
            .CNT_W      (CNT_W),
            .ZERO_UNITS ((g == NUM_CH - 1) ? ZERO_CNT_LAST : ZERO_CNT)
        ) chan_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (reg_we && (reg_chan == CH_W'(g))),
            .wr_sel   (reg_sel_e'(reg_sel)),
            .wr_data  (reg_wdata),
            .hblank   (hblank),
            .vblank   (vblank),
            .special  (special_req[g]),
            .grant    (grant[g]),
            .wb_valid (wb_valid && (wb_chan == CH_W'(g))),
            .wb_src   (wb_src),
            .wb_dst   (wb_dst),
            .ctrl     (ctrl_a[g]),
            .work_src (src_a[g]),
            .work_dst (dst_a[g]),
            .work_cnt (cnt_a[g]),
            .pending  (pend[g]),
            .irq      (irq[g])
        );
    end

    dma4_engine #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W)
    ) engine_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (pend),
        .ch_ctrl   (ctrl_a),
        .ch_src    (src_a),
        .ch_dst    (dst_a),
        .ch_cnt    (cnt_a),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_wide  (bus_wide),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready),
        .grant     (grant),
        .wb_valid  (wb_valid),
        .wb_chan   (wb_chan),
        .wb_src    (wb_src),
        .wb_dst    (wb_dst)
    );

    assign ctrl_rdata = 16'(ctrl_a[rd_chan]);

endmodule

// File: tb/dma4_ctrl_tb.sv
module dma4_ctrl_tb_top;

    localparam logic [31:0] PAT = 32'hC3C3_3C3C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_chan = '0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [1:0]  rd_chan = '0;
    logic [15:0] ctrl_rdata;
    logic        hblank = 1'b0, vblank = 1'b0;
    logic [3:0]  special_req = '0;
    logic        bus_req, bus_we, bus_wide;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic        bus_ready = 1'b1;
    logic [3:0]  irq;

    int vectors = 0, miscompares = 0;
    int writes_seen = 0, reads_seen = 0;
    int irq_cnt [4] = '{0, 0, 0, 0};
    string cur_req = "R12";
    logic [95:0] exp_q [$];   // {src, dst, data}
    logic [1:0]  rdy_phase = '0;

    always #4 clk = ~clk;

    dma4_ctrl #(.ZERO_CNT(3), .ZERO_CNT_LAST(5)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_chan(reg_chan), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .rd_chan(rd_chan), .ctrl_rdata(ctrl_rdata), .hblank(hblank),
        .vblank(vblank), .special_req(special_req), .bus_req(bus_req), .bus_we(bus_we),
        .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .irq(irq)
    );

    assign bus_rdata = bus_addr ^ PAT;

    // memory side: stall one cycle in four
    always @(posedge clk) begin
        #2;
        rdy_phase = rdy_phase + 2'd1;
        bus_ready = (rdy_phase != 2'd2);
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: compare each accepted access with the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 4; i++) if (irq[i]) irq_cnt[i]++;
            if (bus_req && bus_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, {cur_req, " unexpected access"}, bus_addr, 32'h0);
                end else if (!bus_we) begin
                    reads_seen++;
                    chk(bus_addr == exp_q[0][95:64], {cur_req, " read address"}, bus_addr, exp_q[0][95:64]);
                end else begin
                    logic [95:0] e;
                    e = exp_q.pop_front();
                    writes_seen++;
                    chk(bus_addr == e[63:32], {cur_req, " write address"}, bus_addr, e[63:32]);
                    chk(bus_wdata == e[31:0], {cur_req, " write data"}, bus_wdata, e[31:0]);
                end
            end
        end
    end

    function automatic logic [31:0] step(logic [31:0] a, int m, bit wide);
        int d;
        d = wide ? 4 : 2;
        if (m == 1) return a - d;
        if (m == 2) return a;
        return a + d;
    endfunction

    function automatic logic [15:0] mk_ctrl(bit en, bit ie, int tm, bit wide, bit rpt, int sm, int dm);
        return {en, 6'b0, ie, 2'(tm), wide, rpt, 2'(sm), 2'(dm)};
    endfunction

    task automatic expect_block(input logic [31:0] s0, input logic [31:0] d0, input int n,
                                input bit wide, input int sm, input int dm);
        logic [31:0] s, d, v;
        s = wide ? {s0[31:2], 2'b00} : {s0[31:1], 1'b0};
        d = wide ? {d0[31:2], 2'b00} : {d0[31:1], 1'b0};
        for (int k = 0; k < n; k++) begin
            v = s ^ PAT;
            if (!wide) v = {16'h0000, v[15:0]};
            exp_q.push_back({s, d, v});
            s = step(s, sm, wide);
            d = step(d, dm, wide);
        end
    endtask

    task automatic wr(input int ch, input int sel, input logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_chan = 2'(ch); reg_sel = 2'(sel); reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic pulse_hb();
        @(negedge clk); hblank = 1'b1; @(negedge clk); hblank = 1'b0;
    endtask

    task automatic pulse_vb();
        @(negedge clk); vblank = 1'b1; @(negedge clk); vblank = 1'b0;
    endtask

    task automatic pulse_sp(input int ch);
        @(negedge clk); special_req[ch] = 1'b1; @(negedge clk); special_req = '0;
    endtask

    task automatic drain(input string req);
        int t;
        t = 0;
        while (exp_q.size() != 0 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        repeat (8) @(negedge clk);
        chk(exp_q.size() == 0, {req, " block completes"}, 32'(exp_q.size()), 32'd0);
    endtask

    task automatic read_ctrl(input int ch, output logic [15:0] v);
        @(negedge clk);
        rd_chan = 2'(ch);
        #1 v = ctrl_rdata;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog R12 actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] cv;
        int w0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(bus_req == 1'b0, "R12 reset bus_req", 32'(bus_req), 32'd0);
        chk(irq == 4'h0, "R10 reset irq", 32'(irq), 32'd0);
        read_ctrl(0, cv);
        chk(cv == 16'h0, "R8 reset control", 32'(cv), 32'd0);

        // R1, R4: immediate 16-bit block, odd source address, interrupt on
        cur_req = "R1";
        expect_block(32'h0000_1001, 32'h0000_8000, 3, 1'b0, 0, 0);
        wr(0, 0, 32'h0000_1001);
        wr(0, 1, 32'h0000_8000);
        wr(0, 2, 32'd3);
        wr(0, 3, 32'(mk_ctrl(1, 1, 0, 0, 0, 0, 0)));
        drain("R1");
        read_ctrl(0, cv);
        chk(cv[15] == 1'b0, "R8 enable cleared", 32'(cv), 32'(cv & 16'h7FFF));
        chk(irq_cnt[0] == 1, "R10 irq on channel 0", 32'(irq_cnt[0]), 32'd1);

        // R2, R3, R4: channel 3, 32-bit, zero count, decrementing source, fixed destination
        cur_req = "R2";
        w0 = writes_seen;
        expect_block(32'h0000_2003, 32'h0000_9006, 5, 1'b1, 1, 2);
        wr(3, 0, 32'h0000_2003);
        wr(3, 1, 32'h0000_9006);
        wr(3, 2, 32'd0);
        wr(3, 3, 32'(mk_ctrl(1, 0, 0, 1, 0, 1, 2)));
        drain("R2");
        chk(writes_seen - w0 == 5, "R3 zero count on channel 3", 32'(writes_seen - w0), 32'd5);
        chk(irq_cnt[3] == 0, "R10 no irq when disabled", 32'(irq_cnt[3]), 32'd0);

        // R6, R3: vblank trigger, zero count on channel 1, fixed source, decrementing destination
        cur_req = "R6";
        w0 = writes_seen;
        wr(1, 0, 32'h0000_3000);
        wr(1, 1, 32'h0000_7000);
        wr(1, 2, 32'd0);
        wr(1, 3, 32'(mk_ctrl(1, 0, 2, 0, 0, 2, 1)));
        repeat (30) @(negedge clk);
        chk(writes_seen == w0, "R6 no data before trigger", 32'(writes_seen - w0), 32'd0);
        expect_block(32'h0000_3000, 32'h0000_7000, 3, 1'b0, 2, 1);
        pulse_vb();
        drain("R6");
        chk(writes_seen - w0 == 3, "R3 zero count on channel 1", 32'(writes_seen - w0), 32'd3);

        // R7: special request on channel 0 is ignored
        cur_req = "R7";
        w0 = writes_seen;
        wr(0, 0, 32'h0000_0100);
        wr(0, 1, 32'h0000_0200);
        wr(0, 2, 32'd1);
        wr(0, 3, 32'(mk_ctrl(1, 0, 3, 0, 0, 0, 0)));
        pulse_sp(0);
        repeat (20) @(negedge clk);
        chk(writes_seen == w0, "R7 channel 0 special moves nothing", 32'(writes_seen - w0), 32'd0);
        read_ctrl(0, cv);
        chk(cv[15] == 1'b1, "R7 channel 0 stays enabled", 32'(cv), 32'(cv | 16'h8000));
        wr(0, 3, 32'd0);

        // R6: special request on channel 2 runs
        cur_req = "R6";
        w0 = writes_seen;
        expect_block(32'h0000_0400, 32'h0000_0500, 1, 1'b0, 0, 0);
        wr(2, 0, 32'h0000_0400);
        wr(2, 1, 32'h0000_0500);
        wr(2, 2, 32'd1);
        wr(2, 3, 32'(mk_ctrl(1, 0, 3, 0, 0, 0, 0)));
        pulse_sp(2);
        drain("R6");
        chk(writes_seen - w0 == 1, "R6 special on channel 2", 32'(writes_seen - w0), 32'd1);

        // R5: writes after arming do not disturb the working copies
        cur_req = "R5";
        w0 = writes_seen;
        wr(2, 0, 32'h0000_3100);
        wr(2, 1, 32'h0000_3200);
        wr(2, 2, 32'd2);
        wr(2, 3, 32'(mk_ctrl(1, 0, 1, 0, 0, 0, 0)));
        wr(2, 0, 32'h0000_4100);
        wr(2, 2, 32'd1);
        expect_block(32'h0000_3100, 32'h0000_3200, 2, 1'b0, 0, 0);
        pulse_hb();
        drain("R5");
        chk(writes_seen - w0 == 2, "R5 armed count kept", 32'(writes_seen - w0), 32'd2);

        // R9, R11: two repeating channels on hblank; channel 2 armed first
        cur_req = "R11";
        wr(2, 0, 32'h0000_6000);
        wr(2, 1, 32'h0000_B000);
        wr(2, 2, 32'd1);
        wr(2, 3, 32'(mk_ctrl(1, 0, 1, 0, 1, 2, 0)));
        wr(1, 0, 32'h0000_5000);
        wr(1, 1, 32'h0000_A000);
        wr(1, 2, 32'd2);
        wr(1, 3, 32'(mk_ctrl(1, 0, 1, 0, 1, 0, 3)));
        expect_block(32'h0000_5000, 32'h0000_A000, 2, 1'b0, 0, 3);
        expect_block(32'h0000_6000, 32'h0000_B000, 1, 1'b0, 2, 0);
        pulse_hb();
        drain("R11");
        cur_req = "R9";
        expect_block(32'h0000_5004, 32'h0000_A000, 2, 1'b0, 0, 3);
        expect_block(32'h0000_6000, 32'h0000_B002, 1, 1'b0, 2, 0);
        pulse_hb();
        drain("R9");
        read_ctrl(1, cv);
        chk(cv[15] == 1'b1, "R9 channel 1 stays enabled", 32'(cv), 32'(cv | 16'h8000));
        read_ctrl(2, cv);
        chk(cv[15] == 1'b1, "R9 channel 2 stays enabled", 32'(cv), 32'(cv | 16'h8000));
        wr(1, 3, 32'd0);
        wr(2, 3, 32'd0);

        cur_req = "R12";
        chk(reads_seen == writes_seen, "R12 one read per write", 32'(reads_seen), 32'(writes_seen));

        summary();
        $finish;
    end

endmodule